// File: doc/BRIEF.md
# ROI Readout Window Sequencer

This block turns a rectangular region of interest, given as inclusive pixel and line bounds, into a readout schedule for an image sensor that delivers a fixed group of pixels (10 or 16, chosen by a parameter) on each readout clock. Software writes five 16-bit settings as byte pairs into a small shadow register file: the first and last pixel, the first and last line, and the line period. A start pulse copies the shadow set into the active set, but only when the arm input is high. The frame then runs on the active set, so any later shadow write cannot change a frame that is already running.

During a frame the block visits only the lines inside the region. Each line lasts one line period of block clocks. A cycle counter inside the line doubles as the readout-clock index. The clock-valid strobe covers the readout clocks from the group that holds the first pixel to the group that holds the last pixel. For each of those groups the block outputs a per-pixel mask of the pixels that lie inside the region. It also raises a flag on a leading group that carries extra pixels before the region and on a trailing group that carries extra pixels after it. A start with an impossible setup is refused and reported.

Top module: `roi_seq`

## Requirements
- R1: Registers are byte-addressed from `BASE_ADDR` (default 0x24) and each value is stored low byte first. The offsets are: +0/+1 first pixel, +2/+3 last pixel, +4/+5 first line, +6/+7 last line, +8/+9 line period. A write to an address outside that ten-byte window changes no setting.
- R2: At an accepted start with `cfgArm`=1, the shadow set becomes the active set. With `cfgArm`=0 the previous active set is kept. A shadow write during a frame does not alter that frame.
- R3: A start is refused when first pixel > last pixel, when first line > last line, or when the line period ≤ last pixel / `PIX_PER_CLK`. In that case `cfgErr` is high for exactly the one cycle after the start edge, and `busy`, `lineValid` and `frameDone` stay low.
- R4: After an accepted start, `lineValid` and `busy` are high from the next cycle. Each line lasts exactly line-period cycles. `lineIdx` runs from the first line to the last line, one step per line.
- R5: With c the cycle number within a line (0 first), `clkValid` is high exactly when first pixel / `PIX_PER_CLK` ≤ c ≤ last pixel / `PIX_PER_CLK` (division rounded down). `groupIdx` equals c while `clkValid` is high and is 0 otherwise.
- R6: Bit i of `pixMask` is 1 exactly when `clkValid` is high and pixel c·`PIX_PER_CLK`+i lies within [first pixel, last pixel].
- R7: `preScan` is high on the first valid group when first pixel mod `PIX_PER_CLK` ≠ 0. `postScan` is high on the last valid group when last pixel mod `PIX_PER_CLK` ≠ `PIX_PER_CLK`−1. Both are low at all other times.
- R8: `frameDone` is high for one cycle, the cycle after the last cycle of the last line, and `busy` and `lineValid` are low in that cycle.
- R9: A start pulse while `busy` is high is ignored and the running frame continues unchanged.
- R10: Out of reset all outputs are low and the active settings are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Shadow register byte write strobe |
| regAddr | input | 8 | Byte address of the write |
| regWdata | input | 8 | Byte written |
| cfgArm | input | 1 | Allows the shadow set to become active at start |
| start | input | 1 | Frame start request |
| busy | output | 1 | Frame in progress |
| lineValid | output | 1 | Current cycle belongs to a region line |
| lineIdx | output | 16 | Sensor line being read |
| clkValid | output | 1 | Current cycle is a readout clock inside the region |
| groupIdx | output | 16 | Readout-clock index while clkValid |
| pixMask | output | PIX_PER_CLK | Per-pixel in-region mask of the current group |
| preScan | output | 1 | Leading group carries pixels before the region |
| postScan | output | 1 | Trailing group carries pixels after the region |
| frameDone | output | 1 | One-cycle end-of-frame pulse |
| cfgErr | output | 1 | One-cycle refused-start pulse |

## Verification
The line strobes, group index, mask and scan flags are combinational decodes of registered counters. They become valid in the first cycle after the start edge and then follow the counters in the same cycle. `frameDone` and `cfgErr` are registered and so appear one cycle after the condition that causes them. The bench drives inputs and samples outputs on the falling clock edge. Its model steps one expected cycle per falling edge, starting with the cycle after the start edge, and checks the one-cycle pulses in exactly that cycle and again one cycle later.

// File: rtl/roi_pkg.sv
package roi_pkg;
  localparam int COORD_W = 16;

  typedef struct packed {
    logic [COORD_W-1:0] startPix;
    logic [COORD_W-1:0] endPix;
    logic [COORD_W-1:0] startLine;
    logic [COORD_W-1:0] endLine;
    logic [COORD_W-1:0] period;
  } roi_cfg_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadFrame;
    logic runCyc;
  } roi_ctl_t;

  // datapath -> control status
  typedef struct packed {
    logic cfgBad;
    logic lineEnd;
    logic lastLine;
  } roi_sts_t;

  typedef enum logic {ST_IDLE, ST_RUN} roi_state_t;
endpackage

// File: rtl/roi_regfile.sv
module roi_regfile
  import roi_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR = 8'h24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWdata,
  input  logic       cfgArm,
  input  logic       loadFrame,
  output roi_cfg_t   nextCfg,
  output roi_cfg_t   actCfg
);
  localparam int NUM_BYTES = 5 * COORD_W / 8;

  logic [NUM_BYTES*8-1:0] shadowV;
  logic [7:0]             wrOff;
  logic                   wrHit;
  roi_cfg_t               shadowCfg;

  assign wrOff = regAddr - BASE_ADDR;
  assign wrHit = regWe && (regAddr >= BASE_ADDR) && (wrOff < 8'(NUM_BYTES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowV <= '0;
    end else if (wrHit) begin
      for (int b = 0; b < NUM_BYTES; b++) begin
        if (wrOff == 8'(b)) shadowV[b*8 +: 8] <= regWdata;
      end
    end
  end

  // low byte first, fields in address order
  assign shadowCfg.startPix  = shadowV[15:0];
  assign shadowCfg.endPix    = shadowV[31:16];
  assign shadowCfg.startLine = shadowV[47:32];
  assign shadowCfg.endLine   = shadowV[63:48];
  assign shadowCfg.period    = shadowV[79:64];

  assign nextCfg = cfgArm ? shadowCfg : actCfg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          actCfg <= '0;
    else if (loadFrame) actCfg <= nextCfg;
  end

  // R2: the active set only moves at a frame load
  p_active_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !loadFrame |=> $stable(actCfg));
endmodule

// File: rtl/roi_ctrl.sv
module roi_ctrl
  import roi_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  roi_sts_t sts,
  output roi_ctl_t ctl,
  output logic     busy,
  output logic     frameDone,
  output logic     cfgErr
);
  roi_state_t state, nextState;
  logic       frameLast;

  assign frameLast = sts.lineEnd && sts.lastLine;

  always_comb begin
    ctl       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (start && !sts.cfgBad) begin
          ctl.loadFrame = 1'b1;
          nextState     = ST_RUN;
        end
      end
      ST_RUN: begin
        ctl.runCyc = 1'b1;
        if (frameLast) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      frameDone <= 1'b0;
      cfgErr    <= 1'b0;
    end else begin
      state     <= nextState;
      frameDone <= (state == ST_RUN) && frameLast;
      cfgErr    <= (state == ST_IDLE) && start && sts.cfgBad;
    end
  end

  assign busy = (state == ST_RUN);

  // R3: a refused start never opens a frame
  p_err_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !busy);
  // R8: frame end pulse is single-cycle and follows a running frame
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);
  p_done_after_run_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !busy);
  // R9: a frame only ends at the end of its last line
  p_keep_running_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !frameLast) |=> busy);
endmodule

// File: rtl/roi_dp.sv
module roi_dp
  import roi_pkg::*;
#(
  parameter int PIX_PER_CLK = 10
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  roi_ctl_t               ctl,
  input  roi_cfg_t               actCfg,
  input  roi_cfg_t               nextCfg,
  output roi_sts_t               sts,
  output logic                   lineValid,
  output logic [COORD_W-1:0]     lineIdx,
  output logic                   clkValid,
  output logic [COORD_W-1:0]     groupIdx,
  output logic [PIX_PER_CLK-1:0] pixMask,
  output logic                   preScan,
  output logic                   postScan
);
  localparam int  SH_W     = $clog2(PIX_PER_CLK);
  localparam bit  IS_POW2  = (PIX_PER_CLK == (1 << SH_W));
  localparam int  MUL_W    = COORD_W + SH_W + 1;
  localparam logic [COORD_W-1:0] GRP    = COORD_W'(PIX_PER_CLK);
  localparam logic [COORD_W-1:0] GRP_M1 = COORD_W'(PIX_PER_CLK - 1);

  logic [COORD_W-1:0] cycCnt, lineCnt;
  logic [COORD_W-1:0] firstClk, lastClk, nextLastClk;
  logic [COORD_W-1:0] startRem, endRem;
  logic [MUL_W-1:0]   baseIdx;

  // pixel -> readout-clock conversion, shift when the group is a power of two
  generate
    if (IS_POW2) begin : g_shift
      assign firstClk    = actCfg.startPix >> SH_W;
      assign lastClk     = actCfg.endPix   >> SH_W;
      assign nextLastClk = nextCfg.endPix  >> SH_W;
      assign startRem    = actCfg.startPix & GRP_M1;
      assign endRem      = actCfg.endPix   & GRP_M1;
    end else begin : g_div
      assign firstClk    = actCfg.startPix / GRP;
      assign lastClk     = actCfg.endPix   / GRP;
      assign nextLastClk = nextCfg.endPix  / GRP;
      assign startRem    = actCfg.startPix - COORD_W'(firstClk * GRP);
      assign endRem      = actCfg.endPix   - COORD_W'(lastClk * GRP);
    end
  endgenerate

  assign sts.cfgBad   = (nextCfg.startPix > nextCfg.endPix) ||
                        (nextCfg.startLine > nextCfg.endLine) ||
                        (nextCfg.period <= nextLastClk);
  assign sts.lineEnd  = (cycCnt == actCfg.period - COORD_W'(1));
  assign sts.lastLine = (lineCnt == actCfg.endLine);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt  <= '0;
      lineCnt <= '0;
    end else if (ctl.loadFrame) begin
      cycCnt  <= '0;
      lineCnt <= nextCfg.startLine;
    end else if (ctl.runCyc) begin
      if (sts.lineEnd) begin
        cycCnt  <= '0;
        lineCnt <= lineCnt + COORD_W'(1);
      end else begin
        cycCnt  <= cycCnt + COORD_W'(1);
      end
    end
  end

  assign lineValid = ctl.runCyc;
  assign lineIdx   = ctl.runCyc ? lineCnt : '0;
  assign clkValid  = ctl.runCyc && (cycCnt >= firstClk) && (cycCnt <= lastClk);
  assign groupIdx  = clkValid ? cycCnt : '0;
  assign baseIdx   = MUL_W'(cycCnt) * MUL_W'(PIX_PER_CLK);

  generate
    for (genvar i = 0; i < PIX_PER_CLK; i++) begin : g_mask
      logic [MUL_W-1:0] pixAbs;
      assign pixAbs     = baseIdx + MUL_W'(i);
      assign pixMask[i] = clkValid &&
                          (pixAbs >= MUL_W'(actCfg.startPix)) &&
                          (pixAbs <= MUL_W'(actCfg.endPix));
    end
  endgenerate

  assign preScan  = clkValid && (cycCnt == firstClk) && (startRem != '0);
  assign postScan = clkValid && (cycCnt == lastClk) && (endRem != GRP_M1);

  // R4: line number only advances at the end of a line, and stays in range
  p_line_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.runCyc && !sts.lineEnd) |=> $stable(lineCnt));
  p_line_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.runCyc |-> (lineCnt >= actCfg.startLine) && (lineCnt <= actCfg.endLine));
  // R5: readout clocks only inside a line
  p_clk_in_line_r5: assert property (@(posedge clk) disable iff (!rstN)
    clkValid |-> lineValid);
  // R6: every asserted group holds at least one region pixel
  p_mask_nonempty_r6: assert property (@(posedge clk) disable iff (!rstN)
    clkValid |-> (pixMask != '0));
  // R7: flagged groups have their edge pixel outside the region
  p_pre_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    preScan |-> !pixMask[0]);
  p_post_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    postScan |-> !pixMask[PIX_PER_CLK-1]);
endmodule

// File: rtl/roi_seq.sv
module roi_seq
  import roi_pkg::*;
#(
  parameter int         PIX_PER_CLK = 10,
  parameter logic [7:0] BASE_ADDR   = 8'h24
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWe,
  input  logic [7:0]             regAddr,
  input  logic [7:0]             regWdata,
  input  logic                   cfgArm,
  input  logic                   start,
  output logic                   busy,
  output logic                   lineValid,
  output logic [15:0]            lineIdx,
  output logic                   clkValid,
  output logic [15:0]            groupIdx,
  output logic [PIX_PER_CLK-1:0] pixMask,
  output logic                   preScan,
  output logic                   postScan,
  output logic                   frameDone,
  output logic                   cfgErr
);
  roi_cfg_t nextCfg, actCfg;
  roi_ctl_t ctl;
  roi_sts_t sts;

  roi_regfile #(.BASE_ADDR(BASE_ADDR)) u_regs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .cfgArm(cfgArm), .loadFrame(ctl.loadFrame),
    .nextCfg(nextCfg), .actCfg(actCfg)
  );

  roi_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .sts(sts), .ctl(ctl),
    .busy(busy), .frameDone(frameDone), .cfgErr(cfgErr)
  );

  roi_dp #(.PIX_PER_CLK(PIX_PER_CLK)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .actCfg(actCfg), .nextCfg(nextCfg),
    .sts(sts), .lineValid(lineValid), .lineIdx(lineIdx), .clkValid(clkValid),
    .groupIdx(groupIdx), .pixMask(pixMask), .preScan(preScan),
    .postScan(postScan)
  );
endmodule

// File: tb/roi_seq_tb.sv
module roi_seq_tb;
  localparam int P = 10;

  // {startPix, endPix, startLine, endLine, period}
  localparam logic [79:0] VEC [5] = '{
    {16'd0,  16'd19, 16'd0,   16'd1,   16'd4},
    {16'd13, 16'd37, 16'd5,   16'd7,   16'd6},
    {16'd25, 16'd25, 16'd2,   16'd2,   16'd5},
    {16'd30, 16'd49, 16'd100, 16'd102, 16'd8},
    {16'd7,  16'd62, 16'd0,   16'd0,   16'd7}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWe = 1'b0;
  logic [7:0]   regAddr = '0;
  logic [7:0]   regWdata = '0;
  logic         cfgArm = 1'b0;
  logic         start = 1'b0;
  logic         busy, lineValid, clkValid, preScan, postScan, frameDone, cfgErr;
  logic [15:0]  lineIdx, groupIdx;
  logic [P-1:0] pixMask;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  roi_seq #(.PIX_PER_CLK(P)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .cfgArm(cfgArm), .start(start), .busy(busy),
    .lineValid(lineValid), .lineIdx(lineIdx), .clkValid(clkValid),
    .groupIdx(groupIdx), .pixMask(pixMask), .preScan(preScan),
    .postScan(postScan), .frameDone(frameDone), .cfgErr(cfgErr)
  );

  function automatic logic [63:0] obs();
    return {17'b0, lineValid, lineIdx, clkValid, groupIdx, pixMask,
            preScan, postScan, busy};
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrByte(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  // R1: low byte first at 0x24..0x2D
  task automatic loadCfg(input logic [79:0] v);
    for (int f = 0; f < 5; f++) begin
      logic [15:0] val = v[79 - 16*f -: 16];
      wrByte(8'h24 + 8'(2*f), val[7:0]);
      wrByte(8'h25 + 8'(2*f), val[15:8]);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // called in the first cycle after the start edge
  task automatic checkFrame(input logic [79:0] v, input bit midPoke, input string req);
    int sp  = int'(v[79:64]);
    int ep  = int'(v[63:48]);
    int sl  = int'(v[47:32]);
    int el  = int'(v[31:16]);
    int per = int'(v[15:0]);
    for (int k = 0; k < (el - sl + 1) * per; k++) begin
      int c  = k % per;
      int ln = sl + k / per;
      logic cv = (c >= sp / P) && (c <= ep / P);
      logic [P-1:0] m;
      logic pre, post;
      logic [63:0] exp;
      for (int i = 0; i < P; i++) m[i] = cv && (c*P + i >= sp) && (c*P + i <= ep);
      pre  = cv && (c == sp / P) && (sp % P != 0);
      post = cv && (c == ep / P) && (ep % P != P - 1);
      exp  = {17'b0, 1'b1, 16'(ln), cv, cv ? 16'(c) : 16'd0, m, pre, post, 1'b1};
      chk(obs() == exp, {req, " R4 R5 R6 R7 frame cycle"}, obs(), exp);
      // R9 start while busy, R2 shadow write mid-frame
      if (midPoke && k == 3) begin
        start = 1'b1; regWe = 1'b1; regAddr = 8'h24; regWdata = 8'hFF;
      end
      if (midPoke && k == 4) begin
        start = 1'b0; regWe = 1'b0;
      end
      @(negedge clk);
    end
    chk(frameDone && !busy && !lineValid, {req, " R8 done pulse"},
        {61'b0, frameDone, busy, lineValid}, 64'b100);
    @(negedge clk);
    chk(!frameDone && !busy, {req, " R8 done single cycle"},
        {62'b0, frameDone, busy}, 64'b0);
  endtask

  task automatic checkErr(input logic [79:0] v, input string req);
    loadCfg(v);
    cfgArm = 1'b1;
    pulseStart();
    chk(cfgErr && !busy && !lineValid && !frameDone, {req, " R3 refused start"},
        {60'b0, cfgErr, busy, lineValid, frameDone}, 64'b1000);
    @(negedge clk);
    chk(!cfgErr && !busy && !lineValid && !frameDone, {req, " R3 error pulse ends"},
        {60'b0, cfgErr, busy, lineValid, frameDone}, 64'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(obs() == 64'b0 && !frameDone && !cfgErr, "R10 outputs in reset", obs(), 64'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk(obs() == 64'b0 && !frameDone && !cfgErr, "R10 outputs after reset", obs(), 64'b0);

    // table walk: every vector armed and run
    for (int n = 0; n < 5; n++) begin
      loadCfg(VEC[n]);
      cfgArm = 1'b1;
      pulseStart();
      checkFrame(VEC[n], n == 1, $sformatf("vec%0d", n));
    end

    // R2: disarmed start keeps the previous active set
    loadCfg(VEC[0]);
    cfgArm = 1'b0;
    pulseStart();
    checkFrame(VEC[4], 1'b0, "R2 disarmed start");

    // R1: writes just outside the window are ignored
    wrByte(8'h23, 8'hAA);
    wrByte(8'h2E, 8'h55);
    cfgArm = 1'b1;
    pulseStart();
    checkFrame(VEC[0], 1'b0, "R1 stray writes");

    // R3: the three refused setups
    checkErr({16'd40, 16'd39, 16'd0, 16'd0, 16'd9}, "pixel order");
    checkErr({16'd0,  16'd9,  16'd5, 16'd4, 16'd9}, "line order");
    checkErr({16'd7,  16'd62, 16'd0, 16'd0, 16'd6}, "short period");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule